// File: doc/BRIEF.md
# Multi-Mode Single-Bit Flip-Flop Cell

This block holds one bit of state whose update rule is picked by a mode input. The available rules are:

- a set/reset latch where reset wins;
- a set/reset latch where set wins;
- a JK element;
- a data-capture element;
- a toggle element.

Every control input is an ordinary data level. This includes the "logical clock" that drives the edge-triggered modes. The cell samples these levels only on cycles where an update strobe is high, using the real system clock.

The cell finds the logical clock's rising edge itself. It compares the current sample with the sample stored at the previous update.

In the three edge-triggered modes, the set and reset lines act as an override. They are looked at first on every update, whatever the logical clock level. When either one is high, the edge action for that update is skipped.

Next to the stored bit, the cell reports a one-cycle flag. The flag says that an update actually changed the bit.

Top module: `fsr_cell`

## Requirements
- R1: A synchronous reset (`rst` high at a system clock edge) clears `q`, `chg` and the stored logical-clock sample to 0. As a result, `lclk` high at the first update after reset counts as a rising edge.
- R2: On cycles with `upd` low, nothing happens. `q` holds, `chg` is 0, and `lclk` is not sampled.
- R3: With `mode` = 0 (reset-wins latch), an update behaves as follows:
  - `s` alone sets `q`;
  - `r` alone clears `q`;
  - `s` and `r` together clear `q`;
  - neither line high holds `q`.
- R4: With `mode` = 1 (set-wins latch), an update with `s` and `r` both high sets `q`. `s` alone sets `q`, and `r` alone clears it.
- R5: With `mode` = 2, 3 or 4, `s` or `r` high on an update overrides the edge action, whatever the level of `lclk`. When both are high, `q` is cleared if `rdom` = 1 and set if `rdom` = 0.
- R6: A rising edge is `lclk` = 1 at an update whose previous update sampled `lclk` = 0. The stored sample is refreshed on every update, including updates where `s` or `r` took effect.
- R7: With `mode` = 2, a rising edge acts as follows:
  - `j` alone sets `q`;
  - `k` alone clears `q`;
  - `j` and `k` together invert `q`;
  - neither line high holds `q`.
- R8: With `mode` = 3, `q` takes `d` on each rising edge and holds otherwise.
- R9: With `mode` = 4, `q` inverts on each rising edge and holds otherwise.
- R10: With `mode` = 5, 6 or 7, `q` holds and `chg` stays 0.
- R11: `chg` is 1 in exactly the cycle after an update that took an action and changed `q`. It is 0 in all other cycles, including after actions that leave `q` at its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Update strobe; inputs are evaluated only when high |
| mode | input | 3 | Behaviour select: 0 reset-wins latch, 1 set-wins latch, 2 JK, 3 data, 4 toggle |
| rdom | input | 1 | Dominance for modes 2 to 4: 1 reset wins, 0 set wins |
| s | input | 1 | Set level |
| r | input | 1 | Reset level |
| j | input | 1 | JK set level |
| k | input | 1 | JK clear level |
| d | input | 1 | Data level |
| lclk | input | 1 | Logical clock level |
| q | output | 1 | Stored bit |
| chg | output | 1 | One-cycle flag: the last update changed `q` |

## Verification
The data-capture assertion assumes that the updates are back to back, so that the previous cycle's `lclk` equals the stored sample. It fires only when `upd` was high in both cycles.

The other assertions assume that the controls are steady across the clock edge at which they are sampled. The bench therefore changes every input at the falling edge only. Stimulus never leaves inputs undefined, because an unconnected line must read as a plain 0. Strobe-low gaps are placed between updates on purpose, to show that the logical clock is sampled only on updates.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      FM_RS = 3'd0,
      FM_SR = 3'd1,
      FM_JK = 3'd2,
      FM_D  = 3'd3,
      FM_T  = 3'd4
   } fsr_mode_e;

   typedef struct packed {
      logic act;
      logic nxt;
   } fsr_step_t;
endpackage

// File: rtl/fsr_edge.sv
module fsr_edge #(
   parameter logic RST_SAMPLE = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic upd,
   input  logic lclk,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst)
         prev_q <= RST_SAMPLE;
      else if (upd)
         prev_q <= lclk;
   end

   assign rise = lclk & ~prev_q;
endmodule

// File: rtl/fsr_latch.sv
module fsr_latch
   import fsr_pkg::*;
(
   input  logic      s,
   input  logic      r,
   input  logic      r_wins,
   output fsr_step_t res
);
   always_comb begin
      res.act = s | r;
      if (s && r)
         res.nxt = ~r_wins;
      else
         res.nxt = s;
   end
endmodule

// File: rtl/fsr_clocked.sv
module fsr_clocked
   import fsr_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic              rise,
   input  logic              j,
   input  logic              k,
   input  logic              d,
   input  logic              cur,
   output fsr_step_t         res
);
   always_comb begin
      res.act = 1'b0;
      res.nxt = cur;
      if (rise) begin
         case (mode)
            FM_JK: begin
               res.act = j | k;
               if (j && k)  res.nxt = ~cur;
               else if (j)  res.nxt = 1'b1;
               else if (k)  res.nxt = 1'b0;
            end
            FM_D: begin
               res.act = 1'b1;
               res.nxt = d;
            end
            FM_T: begin
               res.act = 1'b1;
               res.nxt = ~cur;
            end
            default: res.act = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/fsr_cell.sv
module fsr_cell
   import fsr_pkg::*;
#(
   parameter int   MODE_BITS = MODE_W,
   parameter logic RST_Q     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 upd,
   input  logic [MODE_BITS-1:0] mode,
   input  logic                 rdom,
   input  logic                 s,
   input  logic                 r,
   input  logic                 j,
   input  logic                 k,
   input  logic                 d,
   input  logic                 lclk,
   output logic                 q,
   output logic                 chg
);
   localparam int LAST_CODE = int'(FM_T);

   generate
      if (MODE_BITS != MODE_W) begin : g_bad_width
         $error("fsr_cell: MODE_BITS must equal the package mode width");
      end
      if (LAST_CODE >= (1 << MODE_BITS)) begin : g_bad_codes
         $error("fsr_cell: mode field too narrow for defined codes");
      end
   endgenerate

   logic              rise;
   logic              r_wins;
   logic              known;
   logic              is_latch;
   fsr_step_t         sr_res;
   fsr_step_t         ck_res;
   fsr_step_t         sel;
   logic [MODE_W-1:0] mode_w;

   assign mode_w = MODE_W'(mode);

   fsr_edge #(.RST_SAMPLE(1'b0)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .upd  (upd),
      .lclk (lclk),
      .rise (rise)
   );

   always_comb begin
      is_latch = (mode_w == FM_RS) || (mode_w == FM_SR);
      known    = (int'(mode_w) <= LAST_CODE);
      case (mode_w)
         FM_RS:   r_wins = 1'b1;
         FM_SR:   r_wins = 1'b0;
         default: r_wins = rdom;
      endcase
   end

   fsr_latch u_latch (
      .s      (s),
      .r      (r),
      .r_wins (r_wins),
      .res    (sr_res)
   );

   fsr_clocked u_clocked (
      .mode (mode_w),
      .rise (rise),
      .j    (j),
      .k    (k),
      .d    (d),
      .cur  (q),
      .res  (ck_res)
   );

   always_comb begin
      if (!known)
         sel = '{act: 1'b0, nxt: q};
      else if (sr_res.act || is_latch)
         sel = sr_res;
      else
         sel = ck_res;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q   <= RST_Q;
         chg <= 1'b0;
      end else begin
         chg <= upd & sel.act & (sel.nxt != q);
         if (upd && sel.act)
            q <= sel.nxt;
      end
   end
endmodule

// File: rtl/fsr_cell_chk.sv
module fsr_cell_chk (
   input logic       clk,
   input logic       rst,
   input logic       upd,
   input logic [2:0] mode,
   input logic       rdom,
   input logic       s,
   input logic       r,
   input logic       d,
   input logic       lclk,
   input logic       q,
   input logic       chg
);
   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !upd |=> ($stable(q) && !chg));

   assert_rs_both_R3: assert property (@(posedge clk) disable iff (rst)
      (upd && mode == 3'd0 && s && r) |=> !q);

   assert_sr_both_R4: assert property (@(posedge clk) disable iff (rst)
      (upd && mode == 3'd1 && s && r) |=> q);

   assert_override_R5: assert property (@(posedge clk) disable iff (rst)
      (upd && mode >= 3'd2 && mode <= 3'd4 && s && r) |=> (q == !$past(rdom)));

   assert_d_capture_R8: assert property (@(posedge clk) disable iff (rst)
      (upd && $past(upd) && mode == 3'd3 && !s && !r && lclk && !$past(lclk))
      |=> (q == $past(d)));

   assert_unused_R10: assert property (@(posedge clk) disable iff (rst)
      (upd && mode > 3'd4) |=> ($stable(q) && !chg));

   assert_changed_R11: assert property (@(posedge clk) disable iff (rst)
      chg |-> (q != $past(q)));
endmodule

bind fsr_cell fsr_cell_chk u_chk (
   .clk  (clk),
   .rst  (rst),
   .upd  (upd),
   .mode (mode),
   .rdom (rdom),
   .s    (s),
   .r    (r),
   .d    (d),
   .lclk (lclk),
   .q    (q),
   .chg  (chg)
);

// File: tb/test_fsr_cell.sv
module test_fsr_cell;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic upd = 1'b0;
   logic [2:0] mode = 3'd0;
   logic rdom = 1'b1;
   logic s = 1'b0, r = 1'b0, j = 1'b0, k = 1'b0, d = 1'b0, lclk = 1'b0;
   logic q, chg;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      logic  eq;
      logic  ech;
      string tag;
   } exp_t;
   exp_t sb[$];

   logic mq = 1'b0;
   logic mprev = 1'b0;

   always #10 clk = ~clk;

   fsr_cell i_fsr_cell (
      .clk(clk), .rst(rst), .upd(upd), .mode(mode), .rdom(rdom),
      .s(s), .r(r), .j(j), .k(k), .d(d), .lclk(lclk), .q(q), .chg(chg)
   );

   task automatic check(input string tag, input logic act_v, input logic exp_v, input string what);
      checks++;
      if (act_v !== exp_v) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act_v, exp_v);
      end
   endtask

   // Drives one cycle of inputs and pushes the expected outcome.
   task automatic step(input string tag, input logic u, input logic [2:0] m, input logic rd,
                       input logic vs, input logic vr, input logic vj, input logic vk,
                       input logic vd, input logic vc);
      logic rise, act, nxt;
      exp_t e;
      @(negedge clk);
      upd = u; mode = m; rdom = rd; s = vs; r = vr; j = vj; k = vk; d = vd; lclk = vc;
      act = 1'b0;
      nxt = mq;
      if (u) begin
         rise = vc && !mprev;
         mprev = vc;
         if (m <= 3'd4 && (vs || vr)) begin
            act = 1'b1;
            if (vs && vr) nxt = (m == 3'd0) ? 1'b0 : (m == 3'd1) ? 1'b1 : !rd;
            else          nxt = vs;
         end else if (m <= 3'd1) begin
            act = 1'b0;
         end else if (rise && m == 3'd2) begin
            act = vj || vk;
            if (vj && vk) nxt = !mq;
            else if (vj)  nxt = 1'b1;
            else if (vk)  nxt = 1'b0;
         end else if (rise && m == 3'd3) begin
            act = 1'b1; nxt = vd;
         end else if (rise && m == 3'd4) begin
            act = 1'b1; nxt = !mq;
         end
      end
      e.ech = act && (nxt != mq);
      if (act) mq = nxt;
      e.eq  = mq;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: one expected item per system clock edge.
   initial begin
      forever begin
         @(posedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            #5;
            check(e.tag, q, e.eq, "q");
            check({e.tag, "/R11"}, chg, e.ech, "chg");
         end
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", q, 1'b0, "q after reset");
      check("R1", chg, 1'b0, "chg after reset");
      rst = 1'b0;
      // R1: lclk high at first update after reset is a rising edge (T mode)
      step("R1", 1, 3'd4, 1, 0,0,0,0,0, 1);
      step("R1", 1, 3'd0, 1, 0,1,0,0,0, 0);
      // R2: strobe low ignores set and logical clock
      step("R2", 0, 3'd0, 1, 1,0,0,0,0, 0);
      step("R2", 0, 3'd4, 1, 0,0,0,0,0, 1);
      // R3: reset-wins latch
      step("R3", 1, 3'd0, 1, 1,0,0,0,0, 0);
      step("R3", 1, 3'd0, 1, 0,0,0,0,0, 0);
      step("R3", 1, 3'd0, 1, 1,1,0,0,0, 0);
      step("R3", 1, 3'd0, 1, 1,0,0,0,0, 0);
      step("R3", 1, 3'd0, 1, 0,1,0,0,0, 0);
      // R4: set-wins latch
      step("R4", 1, 3'd1, 1, 1,1,0,0,0, 0);
      step("R4", 1, 3'd1, 1, 0,1,0,0,0, 0);
      step("R4", 1, 3'd1, 1, 1,0,0,0,0, 0);
      // R2: edge with strobe low is not sampled; next update still sees rise
      step("R2", 1, 3'd4, 1, 0,0,0,0,0, 0);
      step("R2", 0, 3'd4, 1, 0,0,0,0,0, 1);
      step("R2", 0, 3'd4, 1, 0,0,0,0,0, 0);
      step("R2", 1, 3'd4, 1, 0,0,0,0,0, 1);
      // R7: JK
      step("R7", 1, 3'd2, 1, 0,0,0,0,0, 0);
      step("R7", 1, 3'd2, 1, 0,0,1,0,0, 1);
      step("R7", 1, 3'd2, 1, 0,0,0,0,0, 0);
      step("R7", 1, 3'd2, 1, 0,0,0,1,0, 1);
      step("R7", 1, 3'd2, 1, 0,0,0,0,0, 0);
      step("R7", 1, 3'd2, 1, 0,0,1,1,0, 1);
      step("R7", 1, 3'd2, 1, 0,0,0,0,0, 0);
      step("R7", 1, 3'd2, 1, 0,0,1,1,0, 1);
      step("R7", 1, 3'd2, 1, 0,0,0,0,0, 0);
      step("R7", 1, 3'd2, 1, 0,0,0,0,0, 1);
      step("R7", 1, 3'd2, 1, 0,0,1,1,0, 1);
      // R5 / R6: override on an edge consumes the edge
      step("R5", 1, 3'd2, 1, 0,0,0,0,0, 0);
      step("R5", 1, 3'd2, 1, 1,0,0,1,0, 1);
      step("R6", 1, 3'd2, 1, 0,0,0,1,0, 1);
      step("R5", 1, 3'd3, 1, 1,1,0,0,1, 0);
      step("R5", 1, 3'd3, 0, 1,1,0,0,0, 1);
      step("R5", 1, 3'd4, 1, 0,1,0,0,0, 1);
      step("R5", 1, 3'd4, 0, 1,0,0,0,0, 0);
      // R8: data capture
      step("R8", 1, 3'd3, 1, 0,0,0,0,1, 0);
      step("R8", 1, 3'd3, 1, 0,0,0,0,0, 1);
      step("R8", 1, 3'd3, 1, 0,0,0,0,1, 1);
      step("R8", 1, 3'd3, 1, 0,0,0,0,1, 0);
      step("R8", 1, 3'd3, 1, 0,0,0,0,1, 1);
      step("R8", 1, 3'd3, 1, 0,0,0,0,1, 0);
      step("R8", 1, 3'd3, 1, 0,0,0,0,1, 1);
      // R9: toggle
      for (int i = 0; i < 4; i++) begin
         step("R9", 1, 3'd4, 1, 0,0,0,0,0, 0);
         step("R9", 1, 3'd4, 1, 0,0,0,0,0, 1);
         step("R9", 1, 3'd4, 1, 0,0,0,0,0, 1);
      end
      // R10: unused codes
      step("R10", 1, 3'd5, 1, 1,0,0,0,0, 0);
      step("R10", 1, 3'd6, 1, 0,1,1,1,1, 1);
      step("R10", 1, 3'd7, 1, 1,1,0,0,0, 0);
      step("R10", 1, 3'd0, 1, 0,0,0,0,0, 0);
      // R11: action that keeps the same value raises no flag
      step("R11", 1, 3'd0, 1, 1,0,0,0,0, 0);
      step("R11", 1, 3'd0, 1, 1,0,0,0,0, 0);
      step("R11", 1, 3'd0, 1, 0,0,0,0,0, 0);
      // R1: reset mid-run
      @(negedge clk);
      upd = 1'b0;
      wait (sb.size() == 0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R1", q, 1'b0, "q after second reset");
      check("R1", chg, 1'b0, "chg after second reset");
      rst = 1'b0;
      mq = 1'b0;
      mprev = 1'b0;
      step("R1", 1, 3'd4, 1, 0,0,0,0,0, 1);
      @(negedge clk);
      upd = 1'b0;
      wait (sb.size() == 0);
      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule